// File: doc/BRIEF.md
# Watermark Stop/Go Link Flow Controller

This block joins one point-to-point link end to end: a small sender takes phits from a local producer and places them on the link, and a receiver buffers them in a FIFO until the local consumer drains them. The receiver reports back with coarse stop/go messages instead of a per-cycle ready or a credit count. When the buffer fills up to a high threshold it sends stop. When it empties down to a low threshold it sends go. Between the two thresholds nothing changes.

The return path carries the message through a configurable number of register stages, so the sender keeps transmitting for a while after the receiver has asked it to stop. The FIFO is sized with enough room above the high threshold to take every phit still in flight. Optionally the receiver repeats its current state at a fixed period, and the sender treats a repeated message as harmless.

Top module: `wmk_link`

## Requirements
- R1: After reset, `fill` is 0, `drn_valid` is 0, `src_ready` is 1 and `ctl_code` is 2'b00 (no message).
- R2: Every phit accepted at the source port reaches the drain port exactly once, in acceptance order. While the drain stalls, the head phit and its valid flag hold steady.
- R3: The FIFO never overflows. With the drain stalled and the source always valid, `fill` peaks at exactly HI_MARK+RET_DLY+3. Elaboration rejects DEPTH below that value.
- R4: A stop message (`ctl_code`=2'b01) appears one cycle after `fill` first reaches HI_MARK while the link is flowing.
- R5: A go message (`ctl_code`=2'b10) appears one cycle after `fill` falls to LO_MARK while the link is stopped.
- R6: A change of state happens only at the thresholds. Any message that differs from the current state comes one cycle after `fill` equals the matching threshold. While `fill` is strictly between the marks, the state holds.
- R7: With REFRESH>0, the current state is re-sent so that successive messages in a stable state are exactly REFRESH cycles apart. REFRESH=0 removes the repeats.
- R8: `src_ready` falls RET_DLY+1 cycles after a stop message shows on `ctl_code`, and rises RET_DLY+1 cycles after a go message shows.
- R9: Repeated stop messages keep the sender halted: no phit is accepted and no go appears while the drain stays stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Producer offers a phit |
| src_data | input | DATA_W | Producer phit |
| src_ready | output | 1 | Sender accepts a phit this cycle |
| drn_ready | input | 1 | Consumer takes the head phit |
| drn_valid | output | 1 | FIFO holds a phit |
| drn_data | output | DATA_W | Head phit of the FIFO |
| fill | output | $clog2(DEPTH+1) | Current FIFO occupancy |
| ctl_code | output | 2 | Message sent back this cycle: 00 none, 01 stop, 10 go |

## Verification
A threshold crossing shows on `fill` after the push or pop edge. The matching message is due on `ctl_code` one cycle later. The sender's `src_ready` reacts RET_DLY+1 cycles after that message, and in the worst case the FIFO peaks HI_MARK+RET_DLY+3. The bench drives and samples on falling edges and numbers those edges. Each timing check compares the edge index at which an event is first seen against the index of its cause plus the latency above. The ordering and threshold checks use the `fill` sampled one edge before each message.

// File: rtl/wmk_pkg.sv
`timescale 1ns/1ps
package wmk_pkg;
   typedef enum logic [1:0] {
      CTL_NONE = 2'b00,
      CTL_STOP = 2'b01,
      CTL_GO   = 2'b10
   } ctl_e;
endpackage

// File: rtl/wmk_rxfifo.sv
`timescale 1ns/1ps
module wmk_rxfifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DATA_W-1:0]          push_data,
   input  logic                       pop_req,
   output logic                       head_valid,
   output logic [DATA_W-1:0]          head_data,
   output logic [$clog2(DEPTH+1)-1:0] fill
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int FW = $clog2(DEPTH+1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
   localparam logic [FW-1:0] FULL = FW'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_q, rd_q;
   logic [FW-1:0]     cnt_q;
   logic              pop;

   assign head_valid = (cnt_q != '0);
   assign pop        = pop_req && head_valid;
   assign head_data  = mem[rd_q];
   assign fill       = cnt_q;

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
         if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && (cnt_q == FULL) && !pop)); // R3
   AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !pop_req) |=> (head_valid && $stable(head_data))); // R2
endmodule

// File: rtl/wmk_marker.sv
`timescale 1ns/1ps
module wmk_marker
   import wmk_pkg::*;
#(
   parameter int FW      = 5,
   parameter int HI_MARK = 10,
   parameter int LO_MARK = 4,
   parameter int REFRESH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] fill,
   output ctl_e          code
);
   localparam logic [FW-1:0] HI_F = FW'(HI_MARK);
   localparam logic [FW-1:0] LO_F = FW'(LO_MARK);
   localparam int RW = (REFRESH > 1) ? $clog2(REFRESH) : 1;

   logic stopped_q;
   ctl_e code_q;
   logic hit_hi, hit_lo, rep_due;

   assign hit_hi = !stopped_q && (fill >= HI_F);
   assign hit_lo =  stopped_q && (fill <= LO_F);

   generate
      if (REFRESH == 0) begin : g_norep
         assign rep_due = 1'b0;
      end else begin : g_rep
         localparam logic [RW-1:0] TOP = RW'(REFRESH-1);
         logic [RW-1:0] tick_q;
         assign rep_due = (tick_q == TOP);
         always_ff @(posedge clk) begin
            if (!rst_n)                           tick_q <= '0;
            else if (hit_hi || hit_lo || rep_due) tick_q <= '0;
            else                                  tick_q <= tick_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stopped_q <= 1'b0;
         code_q    <= CTL_NONE;
      end else if (hit_hi) begin
         stopped_q <= 1'b1;
         code_q    <= CTL_STOP;
      end else if (hit_lo) begin
         stopped_q <= 1'b0;
         code_q    <= CTL_GO;
      end else if (rep_due) begin
         code_q    <= stopped_q ? CTL_STOP : CTL_GO;
      end else begin
         code_q    <= CTL_NONE;
      end
   end

   assign code = code_q;

   AST_STOP_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped_q && !$past(stopped_q)) |-> ($past(fill) == HI_F)); // R4
   AST_GO_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped_q && $past(stopped_q)) |-> ($past(fill) == LO_F)); // R5
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill > LO_F) && (fill < HI_F)) |=> $stable(stopped_q)); // R6
endmodule

// File: rtl/wmk_sender.sv
`timescale 1ns/1ps
module wmk_sender
   import wmk_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int RET_DLY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   input  ctl_e              ctl_back,
   output logic              link_valid,
   output logic [DATA_W-1:0] link_data
);
   ctl_e ret_code;
   logic paused_q;
   logic accept;

   generate
      if (RET_DLY == 0) begin : g_direct
         assign ret_code = ctl_back;
      end else begin : g_pipe
         ctl_e stage_q [RET_DLY];
         for (genvar s = 0; s < RET_DLY; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)     stage_q[s] <= CTL_NONE;
               else if (s == 0) stage_q[s] <= ctl_back;
               else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign ret_code = stage_q[RET_DLY-1];
      end
   endgenerate

   assign src_ready = !paused_q;
   assign accept    = src_valid && !paused_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         paused_q   <= 1'b0;
         link_valid <= 1'b0;
         link_data  <= '0;
      end else begin
         if (ret_code == CTL_STOP)    paused_q <= 1'b1;
         else if (ret_code == CTL_GO) paused_q <= 1'b0;
         link_valid <= accept;
         if (accept) link_data <= src_data;
      end
   end

   AST_REPEAT_TOLERATED: assert property (@(posedge clk) disable iff (!rst_n)
      (paused_q && (ret_code == CTL_STOP)) |=> paused_q); // R9
   AST_HALT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_code == CTL_STOP) |=> !src_ready); // R8
   AST_RESUME_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_code == CTL_GO) |=> src_ready); // R8
endmodule

// File: rtl/wmk_link.sv
`timescale 1ns/1ps
module wmk_link
   import wmk_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter int HI_MARK = 10,
   parameter int LO_MARK = 4,
   parameter int RET_DLY = 3,
   parameter int REFRESH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       src_valid,
   input  logic [DATA_W-1:0]          src_data,
   output logic                       src_ready,
   input  logic                       drn_ready,
   output logic                       drn_valid,
   output logic [DATA_W-1:0]          drn_data,
   output logic [$clog2(DEPTH+1)-1:0] fill,
   output logic [1:0]                 ctl_code
);
   localparam int FW    = $clog2(DEPTH+1);
   localparam int SLACK = RET_DLY + 3;

   generate
      if (LO_MARK < 0 || LO_MARK >= HI_MARK) begin : g_bad_marks
         $error("wmk_link: LO_MARK must be non-negative and below HI_MARK");
      end
      if (DEPTH < HI_MARK + SLACK) begin : g_bad_slack
         $error("wmk_link: DEPTH must cover HI_MARK plus the in-flight slack");
      end
      if (REFRESH < 0 || RET_DLY < 0) begin : g_bad_cfg
         $error("wmk_link: REFRESH and RET_DLY must be non-negative");
      end
   endgenerate

   logic              link_valid;
   logic [DATA_W-1:0] link_data;
   logic [FW-1:0]     fill_w;
   ctl_e              code_w;

   wmk_sender #(.DATA_W(DATA_W), .RET_DLY(RET_DLY)) u_sender (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_valid  (src_valid),
      .src_data   (src_data),
      .src_ready  (src_ready),
      .ctl_back   (code_w),
      .link_valid (link_valid),
      .link_data  (link_data)
   );

   wmk_rxfifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (link_valid),
      .push_data  (link_data),
      .pop_req    (drn_ready),
      .head_valid (drn_valid),
      .head_data  (drn_data),
      .fill       (fill_w)
   );

   wmk_marker #(.FW(FW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .REFRESH(REFRESH)) u_marker (
      .clk   (clk),
      .rst_n (rst_n),
      .fill  (fill_w),
      .code  (code_w)
   );

   assign fill     = fill_w;
   assign ctl_code = code_w;

   AST_FILL_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      fill_w <= FW'(HI_MARK + SLACK)); // R3
endmodule

// File: tb/wmk_link_tb.sv
`timescale 1ns/1ps
module wmk_link_tb;
   localparam int DW   = 8;
   localparam int DEP  = 16;
   localparam int HI   = 10;
   localparam int LO   = 4;
   localparam int DLY  = 3;
   localparam int REF  = 8;
   localparam int FW   = $clog2(DEP+1);
   localparam int PEAK = HI + DLY + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          src_valid = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic          src_ready;
   logic          drn_ready = 1'b0;
   logic          drn_valid;
   logic [DW-1:0] drn_data;
   logic [FW-1:0] fill;
   logic [1:0]    ctl_code;

   always #4 clk = ~clk;

   wmk_link #(.DATA_W(DW), .DEPTH(DEP), .HI_MARK(HI), .LO_MARK(LO),
              .RET_DLY(DLY), .REFRESH(REF)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
      .src_ready(src_ready), .drn_ready(drn_ready), .drn_valid(drn_valid),
      .drn_data(drn_data), .fill(fill), .ctl_code(ctl_code));

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // stimulus state, owned by the falling-edge process
   bit          src_en = 0;
   int          drn_mode = 0;   // 0 stalled, 1 always, 2 random
   bit          acc_pend = 0;
   logic [DW-1:0] tx_seq = '0;
   logic [DW-1:0] rx_seq = '0;
   int          tx_cnt = 0;
   int          rx_cnt = 0;
   int          ord_bad = 0;
   int          max_fill = 0;
   bit          st_stop = 0;
   int          prev_fill = 0;
   int          hyst_evt = 0;
   int          hyst_bad = 0;
   int          edge_no = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      edge_no++;
      if (rst_n) begin
         if (acc_pend) begin
            tx_seq = tx_seq + 1'b1;
            tx_cnt++;
         end
         src_valid = src_en;
         src_data  = tx_seq;
         acc_pend  = src_en && src_ready;
         case (drn_mode)
            1:       drn_ready = 1'b1;
            2:       drn_ready = ($urandom_range(0, 1) == 1);
            default: drn_ready = 1'b0;
         endcase
         if (drn_ready && drn_valid) begin
            if (drn_data != rx_seq) ord_bad++;
            rx_seq = rx_seq + 1'b1;
            rx_cnt++;
         end
         // R6: a state change must follow the matching threshold by one cycle
         if (ctl_code == 2'b01 && !st_stop) begin
            hyst_evt++;
            if (prev_fill != HI) hyst_bad++;
            st_stop = 1;
         end else if (ctl_code == 2'b10 && st_stop) begin
            hyst_evt++;
            if (prev_fill != LO) hyst_bad++;
            st_stop = 0;
         end
         prev_fill = int'(fill);
         if (int'(fill) > max_fill) max_fill = int'(fill);
      end
   end

   task automatic t_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(fill == '0, "R1 fill", int'(fill), 0);
      check(drn_valid == 1'b0, "R1 drn_valid", int'(drn_valid), 0);
      check(src_ready == 1'b1, "R1 src_ready", int'(src_ready), 1);
      check(ctl_code == 2'b00, "R1 ctl_code", int'(ctl_code), 0);
   endtask

   task automatic t_fill_stop();
      int n_hi = -1, n_stop = -1, n_halt = -1;
      src_en = 1;
      drn_mode = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (n_hi < 0 && int'(fill) == HI) n_hi = edge_no;
         if (n_stop < 0 && ctl_code == 2'b01) n_stop = edge_no;
         if (n_halt < 0 && !src_ready) n_halt = edge_no;
      end
      check(n_stop == n_hi + 1, "R4 stop delay", n_stop - n_hi, 1);
      check(n_halt == n_stop + DLY + 1, "R8 halt delay", n_halt - n_stop, DLY + 1);
      check(max_fill == PEAK, "R3 peak fill", max_fill, PEAK);
      check(int'(fill) == PEAK, "R3 settled fill", int'(fill), PEAK);
   endtask

   task automatic t_repeat();
      int n1 = -1, n2 = -1, ready_seen = 0, go_seen = 0, tx0;
      tx0 = tx_cnt;
      for (int i = 0; i < 4 * REF; i++) begin
         @(negedge clk);
         if (ctl_code == 2'b01) begin
            if (n1 < 0) n1 = edge_no;
            else if (n2 < 0) n2 = edge_no;
         end
         if (ctl_code == 2'b10) go_seen++;
         if (src_ready) ready_seen++;
      end
      check(n1 >= 0 && n2 - n1 == REF, "R7 repeat gap", n2 - n1, REF);
      check(ready_seen == 0, "R9 held by repeats", ready_seen, 0);
      check(go_seen == 0, "R9 no go while stalled", go_seen, 0);
      check(tx_cnt == tx0, "R9 nothing accepted", tx_cnt - tx0, 0);
   endtask

   task automatic t_drain_go();
      int n_lo = -1, n_go = -1, n_run = -1;
      drn_mode = 1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (n_lo < 0 && int'(fill) == LO) n_lo = edge_no;
         if (n_go < 0 && ctl_code == 2'b10) n_go = edge_no;
         if (n_run < 0 && src_ready) n_run = edge_no;
      end
      check(n_lo >= 0 && n_go == n_lo + 1, "R5 go delay", n_go - n_lo, 1);
      check(n_run == n_go + DLY + 1, "R8 resume delay", n_run - n_go, DLY + 1);
      check(ord_bad == 0, "R2 order after drain", ord_bad, 0);
   endtask

   task automatic t_random();
      drn_mode = 2;
      src_en = 1;
      repeat (3000) @(negedge clk);
      src_en = 0;
      drn_mode = 1;
      repeat (60) @(negedge clk);
      check(int'(fill) == 0, "R2 emptied", int'(fill), 0);
      check(rx_cnt == tx_cnt, "R2 no loss", rx_cnt, tx_cnt);
      check(ord_bad == 0, "R2 in order", ord_bad, 0);
      check(max_fill <= DEP, "R3 no overflow", max_fill, DEP);
      check(hyst_evt > 4, "R6 events seen", hyst_evt, 5);
      check(hyst_bad == 0, "R6 changes only at marks", hyst_bad, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_fill_stop();
      t_repeat();
      t_drain_go();
      t_random();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule